// File: doc/BRIEF.md
# Serial NOR Page-Program Sequencer

This block takes one write request (a start address, a byte count and a stream of data bytes on a valid/ready handshake) and programs it into a serial NOR flash through a byte-wide SPI master port. The SPI bit shifter is not part of the block. The block cuts the request into chunks so that no chunk crosses a 256-byte page. Before each chunk it waits for the device to be idle, then sets the device's write latch, and then sends a page-program frame that carries the chunk's address and its data.

The master port takes one byte per `spi_tx_valid`/`spi_tx_ready` handshake while `spi_sel` (chip select, active high) is asserted. For every byte it sends, the master returns exactly one received byte with a one-cycle `spi_rx_valid` pulse. That received byte arrives before the master accepts the next byte. Each status read is a fresh frame of two bytes: opcode 0x05, then a filler byte 0x00. The block uses only the byte received for the filler.

Requests outside the device, and empty requests, finish at once and produce no SPI traffic. A device that stays busy for too many consecutive status reads ends the request with a timeout error.

Top module: `spi_page_prog`

## Requirements
- R1: Each chunk's length is min(256 − (chunk address mod 256), bytes still to write). A request is therefore split only at 256-byte page boundaries, and a request that fills exactly one aligned page is sent as one chunk.
- R2: Before every chunk, the block sends status-read frames (0x05, 0x00). It sends another frame after each returned byte whose bit 0 is 1. It continues once a returned byte has bit 0 equal to 0.
- R3: If POLL_MAX consecutive status reads all return bit 0 = 1, the block raises `err` and `err_timeout` together for one cycle and sends nothing more. POLL_MAX−1 busy reads followed by a ready read still proceed.
- R4: Once the device reads idle, the block sends a frame containing only the byte 0x06.
- R5: The program frame is 0x02, then the chunk address as three bytes with the most significant byte first, then the chunk's data bytes in stream order. The chunk address equals the start address plus the bytes already written.
- R6: A request with start + length > DEV_SIZE produces a one-cycle `err` with `err_timeout` = 0. It produces no SPI traffic, leaves `busy` low, and leaves `wr_count` at 0. A request that ends exactly at DEV_SIZE is accepted.
- R7: A zero-length request produces a one-cycle `done` with `wr_count` = 0 and no SPI traffic.
- R8: Bytes are offered to the SPI port only while `spi_sel` is high, and `spi_sel` goes low for at least one cycle between any two frames.
- R9: `wr_count` is cleared when a request is accepted and increases by one for each data byte the SPI port accepts. At `done`, a one-cycle pulse, it equals the request length.
- R10: `busy` rises in the cycle after a request is accepted and falls in the same cycle as `done` or `err`. A `req_valid` pulse while `busy` is high has no effect on traffic, on the count or on the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_addr | input | 24 | Start address |
| req_len | input | LEN_W | Number of bytes to program |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle error pulse |
| err_timeout | output | 1 | Qualifies `err`: 1 for a poll timeout, 0 for a range error |
| wr_count | output | LEN_W | Data bytes accepted by the SPI port for this request |
| dat_valid | input | 1 | Data byte available |
| dat_byte | input | 8 | Data byte |
| dat_ready | output | 1 | Data byte consumed |
| spi_sel | output | 1 | Chip select, active high |
| spi_tx_valid | output | 1 | Byte offered to the master |
| spi_tx_byte | output | 8 | Byte to send |
| spi_tx_ready | input | 1 | Master accepts the byte |
| spi_rx_valid | input | 1 | Received byte strobe |
| spi_rx_byte | input | 8 | Received byte |

## Verification
The bench builds the block with LEN_W = 16, DEV_SIZE = 2048 and POLL_MAX = 4. The small device size puts the accept/reject edge of the range check within a few hundred bytes of address. A poll limit of four lets the bench reach both sides of the timeout: three busy reads that still proceed, and four that give up. It does this within short runs, while multi-page writes still cross several page boundaries.

// File: rtl/spi_page_prog.sv
module spi_page_prog #(
  parameter int     LEN_W    = 24,
  parameter longint DEV_SIZE = 64'd1048576,
  parameter int     POLL_MAX = 100000,
  parameter int     PAGE_W   = 8
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [23:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             err_timeout,
  output logic [LEN_W-1:0] wr_count,
  input  logic             dat_valid,
  input  logic [7:0]       dat_byte,
  output logic             dat_ready,
  output logic             spi_sel,
  output logic             spi_tx_valid,
  output logic [7:0]       spi_tx_byte,
  input  logic             spi_tx_ready,
  input  logic             spi_rx_valid,
  input  logic [7:0]       spi_rx_byte
);
  localparam int PW = (POLL_MAX > 1) ? $clog2(POLL_MAX) : 1;
  localparam int CW = PAGE_W + 1;

  typedef enum logic [3:0] {
    S_IDLE, S_GAP, S_SR_OP, S_SR_RD, S_SR_WAIT, S_WEN,
    S_PP_OP, S_A2, S_A1, S_A0, S_DATA
  } st_t;

  st_t st, gap_to;
  logic [23:0]      cur;
  logic [LEN_W-1:0] rem;
  logic [CW-1:0]    left;
  logic [PW-1:0]    polls;

  wire           tx_go = spi_tx_valid && spi_tx_ready;
  wire [CW-1:0]  room  = CW'(1 << PAGE_W) - {1'b0, cur[PAGE_W-1:0]};
  wire [CW-1:0]  first = (rem < LEN_W'(room)) ? rem[CW-1:0] : room;
  wire [64:0]    span  = 65'(req_addr) + 65'(req_len);

  assign spi_sel   = !(st == S_IDLE || st == S_GAP);
  assign dat_ready = (st == S_DATA) && spi_tx_ready;

  always_comb begin
    spi_tx_valid = 1'b1;
    spi_tx_byte  = 8'h00;
    unique case (st)
      S_SR_OP: spi_tx_byte = 8'h05;
      S_SR_RD: spi_tx_byte = 8'h00;
      S_WEN:   spi_tx_byte = 8'h06;
      S_PP_OP: spi_tx_byte = 8'h02;
      S_A2:    spi_tx_byte = cur[23:16];
      S_A1:    spi_tx_byte = cur[15:8];
      S_A0:    spi_tx_byte = cur[7:0];
      S_DATA: begin
        spi_tx_valid = dat_valid;
        spi_tx_byte  = dat_byte;
      end
      default: spi_tx_valid = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; gap_to <= S_IDLE;
      cur <= '0; rem <= '0; left <= '0; polls <= '0;
      busy <= 1'b0; done <= 1'b0; err <= 1'b0; err_timeout <= 1'b0;
      wr_count <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (st)
        S_IDLE: if (req_valid) begin
          err_timeout <= 1'b0;
          wr_count    <= '0;
          if (span > 65'(DEV_SIZE)) err <= 1'b1;
          else if (req_len == '0) done <= 1'b1;
          else begin
            busy <= 1'b1; cur <= req_addr; rem <= req_len;
            polls <= '0; st <= S_SR_OP;
          end
        end
        S_GAP:   st <= gap_to;
        S_SR_OP: if (tx_go) st <= S_SR_RD;
        S_SR_RD: if (tx_go) st <= S_SR_WAIT;
        S_SR_WAIT: if (spi_rx_valid) begin
          if (!spi_rx_byte[0]) begin
            polls <= '0; st <= S_GAP; gap_to <= S_WEN;
          end else if (polls == PW'(POLL_MAX - 1)) begin
            st <= S_IDLE; busy <= 1'b0; err <= 1'b1; err_timeout <= 1'b1;
          end else begin
            polls <= polls + 1'b1; st <= S_GAP; gap_to <= S_SR_OP;
          end
        end
        S_WEN: if (tx_go) begin
          left <= first; st <= S_GAP; gap_to <= S_PP_OP;
        end
        S_PP_OP: if (tx_go) st <= S_A2;
        S_A2:    if (tx_go) st <= S_A1;
        S_A1:    if (tx_go) st <= S_A0;
        S_A0:    if (tx_go) st <= S_DATA;
        S_DATA: if (tx_go) begin
          cur      <= cur + 1'b1;
          rem      <= rem - 1'b1;
          left     <= left - 1'b1;
          wr_count <= wr_count + 1'b1;
          if (rem == LEN_W'(1)) begin
            st <= S_IDLE; busy <= 1'b0; done <= 1'b1;
          end else if (left == CW'(1)) begin
            st <= S_GAP; gap_to <= S_SR_OP;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_page_prog_chk.sv
module spi_page_prog_chk #(
  parameter int LEN_W = 24
)(
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             err,
  input logic             spi_sel,
  input logic             spi_tx_valid,
  input logic             spi_tx_ready,
  input logic             dat_valid,
  input logic             dat_ready,
  input logic [LEN_W-1:0] wr_count
);
  assert_tx_in_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    spi_tx_valid |-> spi_sel);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |->
      (wr_count == $past(wr_count) + LEN_W'($past(dat_valid && dat_ready))));

  assert_busy_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> !busy);

  assert_quiet_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_sel);

  assert_data_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dat_ready |-> (spi_sel && spi_tx_ready));

  assert_one_outcome_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
endmodule

bind spi_page_prog spi_page_prog_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .spi_sel(spi_sel), .spi_tx_valid(spi_tx_valid), .spi_tx_ready(spi_tx_ready),
  .dat_valid(dat_valid), .dat_ready(dat_ready), .wr_count(wr_count)
);

// File: tb/sim_spi_page_prog.sv
`timescale 1ns/1ps
module sim_spi_page_prog;
  localparam int LEN_W = 16;
  localparam int DEV   = 2048;
  localparam int PMAX  = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [23:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic busy, done, err, err_timeout, dat_ready, spi_sel, spi_tx_valid;
  logic [LEN_W-1:0] wr_count;
  logic dat_valid = 1'b0;
  logic [7:0] dat_byte = '0, spi_tx_byte, spi_rx_byte = '0;
  logic spi_tx_ready = 1'b0, spi_rx_valid = 1'b0;

  always #10 clk = ~clk;

  spi_page_prog #(.LEN_W(LEN_W), .DEV_SIZE(DEV), .POLL_MAX(PMAX)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_len(req_len), .busy(busy), .done(done), .err(err),
    .err_timeout(err_timeout), .wr_count(wr_count), .dat_valid(dat_valid),
    .dat_byte(dat_byte), .dat_ready(dat_ready), .spi_sel(spi_sel),
    .spi_tx_valid(spi_tx_valid), .spi_tx_byte(spi_tx_byte),
    .spi_tx_ready(spi_tx_ready), .spi_rx_valid(spi_rx_valid),
    .spi_rx_byte(spi_rx_byte));

  int checks = 0, failures = 0;
  int exp_q[$];
  int stall_cfg = 0, busy_left = 0, frame_idx = 0, dat_idx = 0, cyc = 0;
  int model_cnt = 0;
  bit model_busy = 0, prev_sel = 0, rx_pend = 0, running = 0;
  logic [7:0] first_byte = '0, rx_val = '0;

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    spi_tx_ready = (cyc % 4) != 3;
    dat_valid    = (cyc % 7) != 5;
    dat_byte     = pat(dat_idx);
    spi_rx_valid = rx_pend;
    spi_rx_byte  = rx_val;
    rx_pend      = 0;
    #1;
    if (running) begin
      if (prev_sel && !spi_sel) begin
        int e;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : -2;
        check(e == -1, "R8 frame end", 1, e);
      end
      if (spi_tx_valid && spi_tx_ready) begin
        int e;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : -2;
        check(e == int'(spi_tx_byte), "R5 R2 R4 byte", int'(spi_tx_byte), e);
        if (frame_idx == 0) first_byte = spi_tx_byte;
        if (frame_idx == 1 && first_byte == 8'h05) begin
          rx_val = (busy_left > 0) ? 8'h01 : 8'h00;
          if (busy_left > 0) busy_left--;
        end else rx_val = 8'hFF;
        if (frame_idx == 0 && spi_tx_byte == 8'h06) busy_left = stall_cfg;
        rx_pend = 1;
        frame_idx++;
      end
      if (!spi_sel) frame_idx = 0;
      if (done || err) model_busy = 0;
      check(busy == model_busy, "R10 busy", busy, model_busy);
      check(wr_count == LEN_W'(model_cnt), "R9 count", wr_count, model_cnt);
      if (dat_valid && dat_ready) begin
        dat_idx++;
        model_cnt++;
      end
    end
    prev_sel = spi_sel;
    cyc++;
  end

  // kind: 0 normal, 1 zero length, 2 range error, 3 timeout
  task automatic do_req(int addr, int len, int stall, int kind, bit poke);
    int a, rest, i, n;
    if (kind == 0) begin
      a = addr; rest = len; i = 0;
      while (rest > 0) begin
        int room, c;
        room = 256 - (a % 256);
        c = (room < rest) ? room : rest;
        for (int p = 0; p <= stall; p++) begin
          exp_q.push_back(5); exp_q.push_back(0); exp_q.push_back(-1);
        end
        exp_q.push_back(6); exp_q.push_back(-1);
        exp_q.push_back(2);
        exp_q.push_back((a >> 16) & 255);
        exp_q.push_back((a >> 8) & 255);
        exp_q.push_back(a & 255);
        for (int k = 0; k < c; k++) exp_q.push_back(int'(pat(i + k)));
        exp_q.push_back(-1);
        a += c; i += c; rest -= c;
      end
    end else if (kind == 3) begin
      for (int p = 0; p < PMAX; p++) begin
        exp_q.push_back(5); exp_q.push_back(0); exp_q.push_back(-1);
      end
    end
    stall_cfg = stall; busy_left = stall;
    @(negedge clk);
    dat_idx = 0;
    req_valid = 1; req_addr = 24'(addr); req_len = LEN_W'(len);
    @(negedge clk);
    req_valid = 0; model_cnt = 0;
    model_busy = (kind == 0 || kind == 3);
    #2;
    n = 0;
    while (!(done || err) && n < 20000) begin
      @(negedge clk); #2; n++;
      if (poke && n == 40) begin
        req_valid = 1; req_addr = 24'h000007; req_len = LEN_W'(3);
      end
      if (n == 41) req_valid = 0;
    end
    if (kind <= 1) begin
      check(done && !err, "R9 R7 done pulse", done, 1);
      check(wr_count == LEN_W'(len), "R9 R7 final count", wr_count, len);
    end else begin
      check(err && !done, "R6 R3 err pulse", err, 1);
      check(err_timeout == (kind == 3), "R3 R6 err kind", err_timeout, kind == 3);
      check(wr_count == 0, "R3 R6 count zero", wr_count, 0);
    end
    check(exp_q.size() == 0, "R1 R2 R5 all frames seen", exp_q.size(), 0);
    exp_q.delete();
    @(negedge clk); #2;
    check(!done && !err, "R9 single pulse", done | err, 0);
  endtask

  initial begin
    #(20 * 150000);
    checks++; failures++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #2;
    check(!busy && !done && !err && !spi_sel && wr_count == 0,
          "R10 reset state", busy, 0);
    running = 1;
    do_req(24'h010, 20, 0, 0, 0);   // R5 single chunk
    do_req(24'h0F0, 40, 1, 0, 0);   // R1 page crossing, R2 one busy read
    do_req(24'h100, 256, 0, 0, 0);  // R1 exact aligned page
    do_req(24'h2F8, 600, 2, 0, 1);  // R1 four chunks, R10 ignored request
    do_req(24'h400, 5, PMAX - 1, 0, 0); // R3 limit minus one proceeds
    do_req(24'h500, 10, PMAX, 3, 0);    // R3 timeout
    do_req(24'h020, 0, 0, 1, 0);    // R7 zero length
    do_req(DEV - 8, 9, 0, 2, 0);    // R6 one past the end
    do_req(DEV - 8, 8, 0, 0, 0);    // R6 ends exactly at the device size
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule